// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when the analog temperature converter of a sensor core is powered and when a new conversion begins. In normal operation it starts a conversion once per fixed period and keeps the converter powered only until the converter reports that it has finished. For the rest of the period the converter stays off. Every completed serial access restarts the period and launches a fresh conversion. If a serial access begins while a conversion is running, that conversion is abandoned. The result register then keeps the value it held before.

Two configuration inputs select the other modes. The shutdown bit stops all conversion activity, while the stored result stays readable elsewhere. When the bit is cleared, a wake-up delay runs before the first conversion. The single-shot bit keeps the converter off until a trigger pulse arrives, which comes from the serial side when the single-shot pointer value is written. Each trigger runs exactly one conversion. All delays are counted in clock ticks and set by parameters. A stub that counts ticks stands in for the converter and returns a done strobe. The block replies with a one-cycle load strobe whenever a conversion completes normally.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted, power enable, start and load are all low. Leaving reset acts like leaving shutdown: with neither mode bit set, the first start pulse appears WAKE_TICKS+1 clock edges after the first edge that sees reset released.
- R2: In normal mode with no serial activity, consecutive start pulses are exactly PERIOD_TICKS cycles apart. This holds provided the conversion is shorter than the period.
- R3: Power enable rises in the same cycle as the one-cycle start pulse. It stays high until the edge that samples the converter's done strobe and then stays low until the next start. A start pulse is never seen without power enable.
- R4: A normally completed conversion gives exactly one load pulse. That pulse appears in the first cycle with power enable low after the done strobe.
- R5: In normal mode, a serial-finished pulse seen while a conversion runs, while the converter is idle or while an access holds the converter off gives a start pulse in the next cycle. The period is then counted from that start.
- R6: In normal mode, serial busy seen during a conversion drops power enable in the next cycle and gives no load pulse, even when the done strobe arrives in the same cycle. The converter stays off while busy is high. It starts a full new conversion when the access ends.
- R7: While the shutdown bit (configuration bit 0, high = shut down) is set, no start, load or power occurs. A conversion in progress when the bit is set is abandoned without a load pulse.
- R8: After the shutdown bit is cleared with single-shot mode off, the next start pulse appears WAKE_TICKS+1 edges after the first edge that sees the bit low.
- R9: With the single-shot bit (configuration bit 5, high = single-shot) set, the converter is off. It is not woken by serial-finished or busy. Each trigger pulse seen while idle gives a start in the next cycle and one complete conversion with its load pulse, after which power stays off. A conversion already running when the bit is set completes and loads.
- R10: The trigger has no effect in normal mode or while the shutdown bit is set.
- R11: Clearing the single-shot bit, with shutdown clear, goes back to normal mode through the wake-up delay. The first start appears WAKE_TICKS+1 edges later, and periodic starts follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all tick counts refer to it |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shutdown | input | 1 | Configuration bit 0: 1 halts all conversions |
| cfg_oneshot | input | 1 | Configuration bit 5: 1 selects single-shot mode |
| ser_busy | input | 1 | High while a serial access is in progress |
| ser_done | input | 1 | One-cycle pulse when a serial read or write completes |
| oneshot_trig | input | 1 | One-cycle pulse when the single-shot pointer value is written |
| conv_done | input | 1 | One-cycle strobe from the converter when a conversion is finished |
| pwr_en | output | 1 | Analog converter power enable |
| conv_start | output | 1 | One-cycle pulse that begins a conversion |
| result_load | output | 1 | One-cycle strobe that loads the temperature result register |

## Verification
The assertions take for granted that ser_done and oneshot_trig are single-cycle pulses, that the mode bits change only between clock edges, and that conv_done is raised only while pwr_en is high, once per conversion. The bench keeps to this. It drives every input at the falling edge and models the converter as a counter that restarts on each start pulse, advances only while powered, and raises done after a fixed number of powered cycles, shorter than the period. The sweep places the start of a serial access at every cycle of a conversion, including the cycle in which done arrives. This checks that no partial result is ever loaded and that every resumed conversion runs its full length.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,  // converter off, waiting for a mode change or trigger
    ST_WAKE  = 3'd1,  // wake-up delay after shutdown/single-shot exit
    ST_CONV  = 3'd2,  // converter powered and converting
    ST_IDLE  = 3'd3,  // converter off, waiting for the period to elapse
    ST_HOLD  = 3'd4   // serial access in progress, conversion abandoned
  } sched_st_e;

  typedef struct packed {
    sched_st_e nxt;
    logic      start;
    logic      load;
  } sched_step_t;

  // Counter width needed to hold 0 .. lim-1.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  // One scheduling step: next state and the events fired on this edge.
  function automatic sched_step_t sched_step(
    input sched_st_e st,
    input logic      sd,
    input logic      os,
    input logic      busy,
    input logic      sdone,
    input logic      trig,
    input logic      cdone,
    input logic      phit,
    input logic      whit
  );
    sched_step_t r;
    r.nxt   = st;
    r.start = 1'b0;
    r.load  = 1'b0;
    if (sd) begin
      r.nxt = ST_SLEEP;
    end else begin
      case (st)
        ST_SLEEP: begin
          if (os) begin
            if (trig) begin
              r.nxt   = ST_CONV;
              r.start = 1'b1;
            end
          end else begin
            r.nxt = ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (os) begin
            r.nxt = ST_SLEEP;
          end else if (whit) begin
            r.nxt   = ST_CONV;
            r.start = 1'b1;
          end
        end
        ST_CONV: begin
          if (os) begin
            if (cdone) begin
              r.nxt  = ST_SLEEP;
              r.load = 1'b1;
            end
          end else if (sdone) begin
            r.start = 1'b1;
          end else if (busy) begin
            r.nxt = ST_HOLD;
          end else if (cdone) begin
            r.nxt  = ST_IDLE;
            r.load = 1'b1;
          end
        end
        ST_IDLE: begin
          if (os) begin
            r.nxt = ST_SLEEP;
          end else if (sdone || (!busy && phit)) begin
            r.nxt   = ST_CONV;
            r.start = 1'b1;
          end else if (busy) begin
            r.nxt = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (os) begin
            r.nxt = ST_SLEEP;
          end else if (sdone || !busy) begin
            r.nxt   = ST_CONV;
            r.start = 1'b1;
          end
        end
        default: r.nxt = ST_SLEEP;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/conv_sched_tick.sv
module conv_sched_tick #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = conv_sched_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == LAST);

  AST_TICK_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> hit); // R2

endmodule

// File: rtl/conv_sched_fsm.sv
module conv_sched_fsm
  import conv_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_shutdown,
  input  logic      cfg_oneshot,
  input  logic      ser_busy,
  input  logic      ser_done,
  input  logic      oneshot_trig,
  input  logic      conv_done,
  input  logic      period_hit,
  input  logic      wake_hit,
  output sched_st_e st,
  output logic      start_evt,
  output logic      conv_start,
  output logic      result_load,
  output logic      pwr_en
);
  sched_step_t step;

  always_comb begin
    step = sched_step(st, cfg_shutdown, cfg_oneshot, ser_busy, ser_done,
                      oneshot_trig, conv_done, period_hit, wake_hit);
  end

  assign start_evt = step.start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_SLEEP;
      conv_start  <= 1'b0;
      result_load <= 1'b0;
    end else begin
      st          <= step.nxt;
      conv_start  <= step.start;
      result_load <= step.load;
    end
  end

  assign pwr_en = (st == ST_CONV);

  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pwr_en); // R3

  AST_LOAD_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    result_load |-> !pwr_en); // R4

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_load |=> !result_load); // R4

  AST_SERDONE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_done && !cfg_shutdown && !cfg_oneshot &&
          (st == ST_CONV || st == ST_IDLE || st == ST_HOLD)) |-> conv_start); // R5

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_busy && !ser_done && !cfg_oneshot) |-> !result_load); // R6

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_shutdown) |-> (!conv_start && !pwr_en && !result_load)); // R7

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oneshot_trig && cfg_oneshot && !cfg_shutdown && st == ST_SLEEP)
      |-> conv_start); // R9

endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int unsigned PERIOD_TICKS = 100000,
  parameter int unsigned WAKE_TICKS   = 1700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_shutdown,
  input  logic cfg_oneshot,
  input  logic ser_busy,
  input  logic ser_done,
  input  logic oneshot_trig,
  input  logic conv_done,
  output logic pwr_en,
  output logic conv_start,
  output logic result_load
);
  import conv_sched_pkg::*;

  sched_st_e st;
  logic      start_evt;
  logic      period_hit;
  logic      wake_hit;
  logic      in_wake;

  assign in_wake = (st == ST_WAKE);

  // Period measured from the most recent conversion start.
  conv_sched_tick #(.LIMIT(PERIOD_TICKS)) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_evt),
    .en    (1'b1),
    .hit   (period_hit)
  );

  // Wake-up delay, counted only while waking.
  conv_sched_tick #(.LIMIT(WAKE_TICKS)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_wake),
    .en    (in_wake),
    .hit   (wake_hit)
  );

  conv_sched_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shutdown (cfg_shutdown),
    .cfg_oneshot  (cfg_oneshot),
    .ser_busy     (ser_busy),
    .ser_done     (ser_done),
    .oneshot_trig (oneshot_trig),
    .conv_done    (conv_done),
    .period_hit   (period_hit),
    .wake_hit     (wake_hit),
    .st           (st),
    .start_evt    (start_evt),
    .conv_start   (conv_start),
    .result_load  (result_load),
    .pwr_en       (pwr_en)
  );

endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
  localparam int P_T = 20;  // period ticks
  localparam int W_T = 5;   // wake ticks
  localparam int C_T = 8;   // stub conversion length

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shutdown = 1'b0;
  logic cfg_oneshot = 1'b0;
  logic ser_busy = 1'b0;
  logic ser_done = 1'b0;
  logic oneshot_trig = 1'b0;
  logic conv_done;
  logic pwr_en, conv_start, result_load;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int sc = 0;

  always #10 clk = ~clk;

  conv_sched #(.PERIOD_TICKS(P_T), .WAKE_TICKS(W_T)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_shutdown(cfg_shutdown), .cfg_oneshot(cfg_oneshot),
    .ser_busy(ser_busy), .ser_done(ser_done), .oneshot_trig(oneshot_trig),
    .conv_done(conv_done), .pwr_en(pwr_en), .conv_start(conv_start),
    .result_load(result_load)
  );

  // Converter stub: restarts on start, advances only while powered.
  always @(negedge clk) begin
    if (conv_start) sc = 1;
    else if (pwr_en) sc = sc + 1;
  end
  assign conv_done = pwr_en && (sc == C_T);

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      tick;
      n++;
    end while (!conv_start && n < 1000);
  endtask

  // Called at the falling edge where a start is visible.
  task automatic measure_conv(output int pw, output int ld);
    pw = 1;
    ld = 0;
    for (int i = 1; i < 200; i++) begin
      tick;
      if (result_load) begin
        ld = i;
        break;
      end
      if (pwr_en) pw++;
    end
  endtask

  task automatic quiet(input int cycles, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      tick;
      if (conv_start || result_load || pwr_en) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic full_conv(input string tag);
    int pw, ld;
    measure_conv(pw, ld);
    check(pw == C_T, {tag, " power cycles"}, pw, C_T);
    check(ld == C_T, {tag, " load cycle"}, ld, C_T);
    check(pwr_en == 1'b0, {tag, " power off at load"}, pwr_en, 0);
  endtask

  initial begin
    int n;
    repeat (3) tick;
    check(!pwr_en && !conv_start && !result_load, "R1 reset outputs", {pwr_en, conv_start, result_load}, 0);
    rst_n = 1'b1;
    wait_start(n);
    check(n == W_T + 1, "R1 first start after reset", n, W_T + 1);

    // Periodic operation
    for (int p = 0; p < 3; p++) begin
      full_conv("R3 R4 periodic");
      wait_start(n);
      check(n == P_T - C_T, "R2 period", n, P_T - C_T);
    end

    // Serial completion while idle restarts the period
    full_conv("R4 before restart");
    repeat (3) tick;
    ser_done = 1'b1;
    tick;
    check(conv_start == 1'b1, "R5 restart on serial done", conv_start, 1);
    ser_done = 1'b0;
    full_conv("R5 restarted conversion");
    wait_start(n);
    check(n == P_T - C_T, "R5 period from restart", n, P_T - C_T);

    // Abort sweep: busy starts at every cycle of a conversion
    for (int k = 0; k < C_T; k++) begin
      repeat (k) tick;
      ser_busy = 1'b1;
      tick;
      check(!pwr_en && !result_load, "R6 abort drops power", {pwr_en, result_load}, 0);
      quiet(3, "R6 held off while busy");
      ser_busy = 1'b0;
      ser_done = 1'b1;
      tick;
      check(conv_start == 1'b1, "R6 resume after access", conv_start, 1);
      ser_done = 1'b0;
      full_conv("R6 resumed full conversion");
      wait_start(n);
      check(n == P_T - C_T, "R6 R5 period after resume", n, P_T - C_T);
    end

    // Shutdown during a conversion
    repeat (3) tick;
    cfg_shutdown = 1'b1;
    tick;
    check(!pwr_en && !result_load, "R7 shutdown abandons conversion", {pwr_en, result_load}, 0);
    quiet(P_T, "R7 no activity in shutdown");
    oneshot_trig = 1'b1;
    ser_done = 1'b1;
    tick;
    oneshot_trig = 1'b0;
    ser_done = 1'b0;
    check(!conv_start && !pwr_en, "R10 trigger ignored in shutdown", conv_start, 0);
    quiet(2 * P_T, "R7 still quiet");
    cfg_shutdown = 1'b0;
    wait_start(n);
    check(n == W_T + 1, "R8 wake delay", n, W_T + 1);
    full_conv("R8 first conversion after wake");

    // Trigger in normal mode has no effect
    tick;
    oneshot_trig = 1'b1;
    tick;
    check(conv_start == 1'b0, "R10 trigger ignored in normal mode", conv_start, 0);
    oneshot_trig = 1'b0;
    wait_start(n);
    check(n == P_T - C_T - 2, "R10 R2 period undisturbed", n, P_T - C_T - 2);

    // Single-shot mode entered during a conversion
    cfg_oneshot = 1'b1;
    full_conv("R9 running conversion completes");
    quiet(P_T, "R9 powered down");
    ser_busy = 1'b1;
    tick;
    ser_busy = 1'b0;
    ser_done = 1'b1;
    tick;
    ser_done = 1'b0;
    quiet(2 * P_T, "R9 serial ignored");
    oneshot_trig = 1'b1;
    tick;
    check(conv_start == 1'b1, "R9 trigger starts", conv_start, 1);
    oneshot_trig = 1'b0;
    ser_busy = 1'b1;
    full_conv("R9 single conversion ignores busy");
    ser_busy = 1'b0;
    quiet(2 * P_T, "R9 single conversion only");
    cfg_shutdown = 1'b1;
    tick;
    oneshot_trig = 1'b1;
    tick;
    oneshot_trig = 1'b0;
    quiet(3, "R10 trigger ignored with shutdown");
    cfg_shutdown = 1'b0;
    quiet(P_T, "R9 no wake while single-shot");
    oneshot_trig = 1'b1;
    tick;
    check(conv_start == 1'b1, "R9 second trigger starts", conv_start, 1);
    oneshot_trig = 1'b0;
    full_conv("R9 second single conversion");

    // Back to normal mode
    cfg_oneshot = 1'b0;
    wait_start(n);
    check(n == W_T + 1, "R11 wake on leaving single-shot", n, W_T + 1);
    full_conv("R11 conversion");
    wait_start(n);
    check(n == P_T - C_T, "R11 periodic again", n, P_T - C_T);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule